// File: doc/BRIEF.md
# Narrow Program Memory Word Bridge

This bridge connects a processor memory port that works in 32-bit words to a program memory whose read port is only 16 bits wide. A single 32-bit word is built from two back-to-back halfword reads. The bridge also inserts the extra cycles this memory needs. Data reads get an address-decode cycle before they start. Redirected instruction fetches get one decode cycle. After any data access there are idle dead cycles before the next request is accepted. When a word is complete, the bridge raises a one-cycle ready pulse to the core.

The core presents one request at a time and holds it until it sees ready. For each request the core gives:

- an address;
- a flag marking it as a data access rather than an instruction fetch;
- a halfword flag for data;
- a redirect flag for fetches that follow a change of program flow;
- a word count for multiple-word loads.

A mode input selects 32-bit or 16-bit instruction fetch. In 16-bit mode, instruction fetches read a single halfword. The memory read port is combinational: read data is valid in the same cycle the read strobe and address are driven.

Top module: `nvm_fetch_bridge`

## Requirements
- R1: A synchronous active-high reset brings the bridge to idle. After reset, `rsp_ready` and `mem_rd` are low, and a reset in the middle of a transfer abandons that transfer.
- R2: A request is accepted at the end of an idle cycle in which `req` is high and `rsp_ready` is low. The request fields are captured at that edge, and no memory read is issued during the accepting cycle.
- R3: A 32-bit instruction fetch (`isa16`=0, `req_data`=0) issues two consecutive read cycles, starting the cycle after acceptance. The first read is at the address with bits 1:0 cleared and the second is at that address plus 2.
- R4: A 32-bit result is returned little-endian as {second halfword, first halfword}. `rsp_ready` is high for exactly one cycle, the cycle after the last read, and `rsp_word` is valid in that cycle.
- R5: A 16-bit instruction fetch (`isa16`=1, `req_data`=0) issues a single read at the address with bit 0 cleared. The result is that halfword zero-extended.
- R6: A fetch with `req_redirect`=1 spends exactly one cycle with no memory read after acceptance, then performs its reads. This holds in both fetch modes.
- R7: A data word read (`req_data`=1, `req_half`=0, `req_count` below 2) spends one decode cycle without a read, then two read cycles as in R3. This holds whatever the value of `isa16`.
- R8: A halfword data read (`req_data`=1, `req_half`=1, `req_count` below 2) spends one decode cycle, then one read at the address with bit 0 cleared, and returns the halfword zero-extended. `req_half` has no effect on instruction fetches.
- R9: After the ready pulse of a data access, the bridge waits `DEAD_CYC` further cycles (default 1) before it can accept a request. After an instruction fetch, a new request can be accepted in the cycle right after the ready pulse.
- R10: A data request with `req_count`=N, where N is from 2 to `MAX_BURST`, reads N words at base, base+4, and so on. Base is the address with bits 1:0 cleared. Each word takes one decode cycle and two read cycles. Each word gets its own ready pulse, which coincides with the decode cycle of the next word. `req_half` is ignored for such requests.
- R11: `req_redirect` and `isa16` have no effect on data accesses. A data request always takes exactly one decode cycle per word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| isa16 | input | 1 | 1 selects 16-bit instruction fetch, 0 selects 32-bit |
| req | input | 1 | Request valid, held until ready |
| req_addr | input | AW (20) | Byte address of the request |
| req_data | input | 1 | 1 marks a data access, 0 an instruction fetch |
| req_half | input | 1 | Halfword data read |
| req_redirect | input | 1 | Fetch follows a change of program flow |
| req_count | input | CW (5) | Number of words for a multiple load (0 or 1 means single) |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW (20) | Halfword-aligned memory read address |
| mem_rdata | input | MW (16) | Memory read data, valid in the strobe cycle |
| rsp_ready | output | 1 | One-cycle pulse, response word valid |
| rsp_word | output | 2*MW (32) | Assembled response word |

## Verification
Most internal faults in this bridge surface within one or two cycles. A wrong state or step counter moves the read strobe into the wrong cycle, so the misplaced strobe is visible on the very next clock. A wrong address register puts a bad halfword address on `mem_addr` in the first read cycle. A stale low-half register appears as a corrupt upper or lower half of `rsp_word` in the ready cycle. A miscounted burst or dead-time counter shows up as a ready pulse or acceptance that comes one cycle early or late. The slowest fault to appear is a wrong remaining-word count in a 16-word load, which only becomes visible at the end of the burst. Comparing the read strobe, address and ready on every clock against an independent cycle model catches each of these at the first cycle where they differ.

// File: rtl/nfb_pkg.sv
package nfb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_DEC  = 3'd1,
      ST_LO   = 3'd2,
      ST_HI   = 3'd3,
      ST_DEAD = 3'd4
   } nfb_state_e;
endpackage

// File: rtl/nfb_seq.sv
module nfb_seq
   import nfb_pkg::*;
#(
   parameter int AW        = 20,
   parameter int MAX_BURST = 16,
   parameter int DEAD_CYC  = 1,
   parameter int CW        = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          isa16,
   input  logic          req,
   input  logic [AW-1:0] req_addr,
   input  logic          req_data,
   input  logic          req_half,
   input  logic          req_redirect,
   input  logic [CW-1:0] req_count,
   input  logic          rsp_ready,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   output logic          lo_take,
   output logic          half_done,
   output logic          word_done
);
   localparam bit HAS_DEAD = (DEAD_CYC > 0);
   localparam int DW       = HAS_DEAD ? $clog2(DEAD_CYC + 1) : 1;

   nfb_state_e    state_q;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] left_q;
   logic          data_q;
   logic          half_q;
   logic          dead_done;

   logic          accept;
   logic          multi;
   logic          sel_half;
   nfb_state_e    end_state;

   assign accept    = (state_q == ST_IDLE) && req && !rsp_ready;
   assign multi     = req_data && (req_count >= CW'(2));
   assign sel_half  = req_data ? (req_half && !multi) : isa16;
   assign end_state = (data_q && HAS_DEAD) ? ST_DEAD : ST_IDLE;

   generate
      if (HAS_DEAD) begin : g_dead
         logic [DW-1:0] dead_cnt;
         always_ff @(posedge clk) begin
            if (rst || state_q != ST_DEAD) dead_cnt <= '0;
            else                           dead_cnt <= dead_cnt + DW'(1);
         end
         assign dead_done = (dead_cnt == DW'(DEAD_CYC));
      end else begin : g_no_dead
         assign dead_done = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         left_q  <= '0;
         data_q  <= 1'b0;
         half_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  data_q  <= req_data;
                  half_q  <= sel_half;
                  left_q  <= multi ? req_count : CW'(1);
                  addr_q  <= sel_half ? (req_addr & ~AW'(1)) : (req_addr & ~AW'(3));
                  state_q <= (req_data || req_redirect) ? ST_DEC : ST_LO;
               end
            end
            ST_DEC:  state_q <= ST_LO;
            ST_LO:   state_q <= half_q ? end_state : ST_HI;
            ST_HI: begin
               if (left_q > CW'(1)) begin
                  left_q  <= left_q - CW'(1);
                  addr_q  <= addr_q + AW'(4);
                  state_q <= ST_DEC;
               end else begin
                  state_q <= end_state;
               end
            end
            ST_DEAD: if (dead_done) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd    = (state_q == ST_LO) || (state_q == ST_HI);
   assign mem_addr  = (state_q == ST_HI) ? (addr_q + AW'(2)) : addr_q;
   assign lo_take   = (state_q == ST_LO) && !half_q;
   assign half_done = (state_q == ST_LO) && half_q;
   assign word_done = (state_q == ST_HI);

   // second halfword read follows the first at the next halfword address (R3)
   assert_hi_after_lo_R3: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_HI) |-> ($past(state_q) == ST_LO && mem_addr == $past(mem_addr) + AW'(2)));

   // every data read is preceded by a decode cycle (R7)
   assert_data_decoded_R7: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_LO && data_q) |-> ($past(state_q) == ST_DEC));

   // accepting cycle issues no read (R2)
   assert_accept_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      ($past(accept) && !$past(rst)) |-> !$past(mem_rd));

   // multiple-load length within the supported range (R10)
   assert_burst_bound_R10: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && req && req_data) |-> (req_count <= CW'(MAX_BURST)));
endmodule

// File: rtl/nfb_pack.sv
module nfb_pack #(
   parameter int MW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [MW-1:0] mem_rdata,
   input  logic          lo_take,
   input  logic          half_done,
   input  logic          word_done,
   output logic          rsp_ready,
   output logic [2*MW-1:0] rsp_word
);
   logic [MW-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q      <= '0;
         rsp_ready <= 1'b0;
         rsp_word  <= '0;
      end else begin
         rsp_ready <= half_done || word_done;
         if (lo_take)        lo_q     <= mem_rdata;
         if (half_done)      rsp_word <= {{MW{1'b0}}, mem_rdata};
         else if (word_done) rsp_word <= {mem_rdata, lo_q};
      end
   end

   // ready is a single-cycle pulse (R4)
   assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (rst)
      rsp_ready |=> !rsp_ready);

   // ready leaves reset low (R1)
   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !rsp_ready);
endmodule

// File: rtl/nvm_fetch_bridge.sv
module nvm_fetch_bridge #(
   parameter int AW        = 20,
   parameter int MW        = 16,
   parameter int MAX_BURST = 16,
   parameter int DEAD_CYC  = 1,
   localparam int CW       = $clog2(MAX_BURST + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            isa16,
   input  logic            req,
   input  logic [AW-1:0]   req_addr,
   input  logic            req_data,
   input  logic            req_half,
   input  logic            req_redirect,
   input  logic [CW-1:0]   req_count,
   output logic            mem_rd,
   output logic [AW-1:0]   mem_addr,
   input  logic [MW-1:0]   mem_rdata,
   output logic            rsp_ready,
   output logic [2*MW-1:0] rsp_word
);
   generate
      if (AW < 3)                         begin : g_bad_aw    $error("AW must be at least 3"); end
      if (MW != 16)                       begin : g_bad_mw    $error("halfword port must be 16 bits"); end
      if (MAX_BURST < 2 || MAX_BURST > 16) begin : g_bad_burst $error("MAX_BURST must be 2..16"); end
      if (DEAD_CYC < 0 || DEAD_CYC > 8)   begin : g_bad_dead  $error("DEAD_CYC must be 0..8"); end
   endgenerate

   logic lo_take;
   logic half_done;
   logic word_done;

   nfb_seq #(
      .AW(AW), .MAX_BURST(MAX_BURST), .DEAD_CYC(DEAD_CYC), .CW(CW)
   ) u_seq (
      .clk(clk), .rst(rst), .isa16(isa16), .req(req), .req_addr(req_addr),
      .req_data(req_data), .req_half(req_half), .req_redirect(req_redirect),
      .req_count(req_count), .rsp_ready(rsp_ready), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .lo_take(lo_take), .half_done(half_done),
      .word_done(word_done)
   );

   nfb_pack #(.MW(MW)) u_pack (
      .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .lo_take(lo_take),
      .half_done(half_done), .word_done(word_done), .rsp_ready(rsp_ready),
      .rsp_word(rsp_word)
   );

   // a ready pulse always closes a read cycle (R4)
   assert_ready_after_read_R4: assert property (@(posedge clk) disable iff (rst)
      (rsp_ready && !$past(rst)) |-> $past(mem_rd));
endmodule

// File: tb/nvm_fetch_bridge_bench.sv
`timescale 1ns/1ps
module nvm_fetch_bridge_bench;
   localparam int DEAD = 1;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        isa16 = 1'b0;
   logic        req = 1'b0;
   logic [19:0] req_addr = '0;
   logic        req_data = 1'b0;
   logic        req_half = 1'b0;
   logic        req_redirect = 1'b0;
   logic [4:0]  req_count = '0;
   logic        mem_rd;
   logic [19:0] mem_addr;
   logic [15:0] mem_rdata;
   logic        rsp_ready;
   logic [31:0] rsp_word;

   int checks = 0;
   int errors = 0;
   int ready_seen = 0;
   string cur_tag = "R2";

   bit          q_rd[$];
   logic [19:0] q_addr[$];
   bit          q_rdy[$];
   logic [31:0] q_word[$];
   string       q_tag[$];

   always #2.5 clk = ~clk;

   function automatic logic [15:0] memv(input logic [19:0] a);
      return a[16:1] ^ 16'hA5C3;
   endfunction

   assign mem_rdata = memv(mem_addr);

   nvm_fetch_bridge u_nvm_fetch_bridge (
      .clk(clk), .rst(rst), .isa16(isa16), .req(req), .req_addr(req_addr),
      .req_data(req_data), .req_half(req_half), .req_redirect(req_redirect),
      .req_count(req_count), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .rsp_ready(rsp_ready), .rsp_word(rsp_word)
   );

   task automatic push_e(input bit rd, input logic [19:0] a, input bit rdy,
                         input logic [31:0] w, input string t);
      q_rd.push_back(rd); q_addr.push_back(a); q_rdy.push_back(rdy);
      q_word.push_back(w); q_tag.push_back(t);
   endtask

   // expected cycles following an accepted request
   task automatic build(input logic [19:0] a, input bit d, input bit h, input bit r,
                        input bit m16, input int cnt, input string t);
      int          wrd;
      bit          hf;
      bit          pend;
      logic [31:0] pw;
      logic [19:0] base;
      wrd  = (d && cnt >= 2) ? cnt : 1;
      hf   = d ? (h && cnt < 2) : m16;
      pend = 1'b0;
      pw   = '0;
      if (d || r) push_e(1'b0, '0, 1'b0, '0, t);
      for (int i = 0; i < wrd; i++) begin
         if (i > 0) begin push_e(1'b0, '0, pend, pw, t); pend = 1'b0; end
         if (hf) begin
            base = a & ~20'h1;
            push_e(1'b1, base, 1'b0, '0, t);
            pw = {16'h0, memv(base)};
         end else begin
            base = (a & ~20'h3) + 20'(4 * i);
            push_e(1'b1, base, 1'b0, '0, t);
            push_e(1'b1, base + 20'h2, 1'b0, '0, t);
            pw = {memv(base + 20'h2), memv(base)};
         end
         pend = 1'b1;
      end
      push_e(1'b0, '0, 1'b1, pw, t);
      if (d) for (int k = 0; k < DEAD; k++) push_e(1'b0, '0, 1'b0, '0, t);
   endtask

   // per-cycle comparison against the reference model
   always @(negedge clk) begin
      if (rst) begin
         q_rd.delete(); q_addr.delete(); q_rdy.delete(); q_word.delete(); q_tag.delete();
      end else begin
         bit          e_rd;
         logic [19:0] e_addr;
         bit          e_rdy;
         logic [31:0] e_word;
         string       e_tag;
         bit          was_empty;
         was_empty = (q_rd.size() == 0);
         if (was_empty) begin
            e_rd = 1'b0; e_addr = '0; e_rdy = 1'b0; e_word = '0; e_tag = "R2";
         end else begin
            e_rd = q_rd.pop_front(); e_addr = q_addr.pop_front(); e_rdy = q_rdy.pop_front();
            e_word = q_word.pop_front(); e_tag = q_tag.pop_front();
         end
         checks++;
         if (mem_rd !== e_rd || (e_rd && mem_addr !== e_addr) || rsp_ready !== e_rdy ||
             (e_rdy && rsp_word !== e_word)) begin
            errors++;
            $display("FAIL %s t=%0t actual rd=%0b addr=%h ready=%0b word=%h expected rd=%0b addr=%h ready=%0b word=%h",
                     e_tag, $time, mem_rd, mem_addr, rsp_ready, rsp_word, e_rd, e_addr, e_rdy, e_word);
         end
         if (rsp_ready === 1'b1) ready_seen++;
         if (was_empty && req) build(req_addr, req_data, req_half, req_redirect, isa16,
                                     int'(req_count), cur_tag);
      end
   end

   // starts at a posedge, returns at the posedge closing the last ready cycle
   task automatic issue(input logic [19:0] a, input bit d, input bit h, input bit r,
                        input bit m16, input int cnt, input string t);
      int need;
      #1;
      req = 1'b1; req_addr = a; req_data = d; req_half = h; req_redirect = r;
      isa16 = m16; req_count = cnt[4:0]; cur_tag = t; ready_seen = 0;
      need = (d && cnt >= 2) ? cnt : 1;
      while (ready_seen < need) @(posedge clk);
   endtask

   task automatic drop(input int n);
      #1; req = 1'b0;
      repeat (n) @(posedge clk);
   endtask

   task automatic check_idle(input string t);
      @(negedge clk);
      #0.1;
      checks++;
      if (mem_rd !== 1'b0 || rsp_ready !== 1'b0) begin
         errors++;
         $display("FAIL %s idle actual rd=%0b ready=%0b expected rd=0 ready=0", t, mem_rd, rsp_ready);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R2 watchdog actual=no completion expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      check_idle("R1");                          // R1 reset state
      @(posedge clk);
      issue(20'h01236, 0, 0, 0, 0, 0, "R3 R4");  // R3 R4 32-bit fetch, alignment
      drop(2);
      issue(20'h0456B, 0, 0, 0, 1, 0, "R5");     // R5 16-bit fetch
      drop(1);
      issue(20'h02000, 0, 0, 1, 0, 0, "R6");     // R6 redirect, 32-bit mode
      issue(20'h02102, 0, 0, 1, 1, 0, "R6");     // R6 redirect, 16-bit mode, back to back
      drop(1);
      issue(20'h08011, 1, 0, 0, 1, 0, "R7 R11"); // R7 R11 data word, isa16 ignored
      drop(1);
      issue(20'h08020, 1, 0, 1, 0, 0, "R11");    // R11 redirect ignored for data
      drop(1);
      issue(20'h08013, 1, 1, 0, 0, 0, "R8");     // R8 halfword data
      drop(1);
      issue(20'h03006, 0, 1, 0, 0, 0, "R8");     // R8 half flag ignored on fetch
      drop(1);
      issue(20'h0A004, 1, 1, 0, 0, 2, "R10");    // R10 two-word load, half ignored
      drop(1);
      issue(20'h0FFC3, 1, 0, 0, 0, 16, "R10");   // R10 sixteen-word load
      drop(1);
      issue(20'h0B000, 1, 0, 0, 0, 1, "R10");    // R10 count 1 is single
      issue(20'h0C000, 0, 0, 0, 0, 0, "R9");     // R9 fetch held through dead time
      issue(20'h0C010, 0, 0, 0, 0, 0, "R9");     // R9 fetch right after fetch
      issue(20'h0D000, 1, 1, 0, 0, 0, "R9");     // R9 data after fetch
      issue(20'h0D100, 1, 0, 0, 0, 0, "R9");     // R9 data after data
      drop(2);
      // R1 reset in the middle of a transfer
      #1; req = 1'b1; req_addr = 20'h05000; req_data = 1'b1; req_half = 1'b0;
      req_redirect = 1'b0; isa16 = 1'b0; req_count = 5'd4; cur_tag = "R1";
      repeat (3) @(posedge clk);
      #1; rst = 1'b1; req = 1'b0;
      repeat (2) @(posedge clk);
      #1; rst = 1'b0;
      check_idle("R1");
      check_idle("R1");
      @(posedge clk);
      issue(20'h01000, 0, 0, 0, 0, 0, "R1");     // R1 normal service after reset
      drop(4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule